// File: doc/BRIEF.md
# Serial Receive Channel with Character Queue and Idle Watchdog

This block is one asynchronous serial receive channel. It watches a serial line that idles high. It finds each start bit and collects 5 to 8 data bits, least significant bit first, plus an optional parity bit. It then samples one stop bit. Every finished character goes into an eight-deep queue together with three status flags: parity error, framing error and break. A consumer drains the queue through a show-ahead pop port.

In the normal mode, a baud-rate enable tick arriving at sixteen times the bit rate drives the timing. The start bit is confirmed at its mid-point, and every later bit is sampled at its centre. In the alternative mode, an external bit-rate clock drives the timing, and the line is sampled once on each rising edge of that clock.

The block can raise two interrupts. The fill interrupt rises once the queue holds a selectable number of characters. The watchdog rises when characters sit in the queue and nothing has happened for 64 bit times.

Top module: `serial_rx_channel`

## Requirements
- R1: With `cfgX1`=0 the line is sampled once every 16 `baudTick` pulses. Samples fall at bit centres, starting 8 ticks after the first low tick. `cfgDataBits` 0,1,2,3 selects 5,6,7,8 data bits. The first received bit lands in `rdData[0]`, and unused upper data bits read 0.
- R2: `cfgParMode` selects the parity check: 00 none, 01 even, 10 odd, 11 fixed. In fixed mode the parity bit must equal `cfgForceVal`. A mismatch sets `rdParErr` for that character.
- R3: A character whose stop bit is sampled low is still queued, with `rdFrmErr`=1. The low stop sample is then taken as the centre of a new start bit.
- R4: In 16X mode, if the line is high again at the start-bit centre, the start is false. The receiver returns to idle and queues nothing.
- R5: A frame whose data bits, parity bit and stop bit are all low is a break. It queues one entry with data 0, `rdBrk`=1 and `rdFrmErr`=1, and pulses `breakStart` for one cycle. Nothing more is queued while the line stays low. When the line is seen high again, `breakEnd` pulses for one cycle.
- R6: A break that begins inside a character first yields that character with `rdFrmErr`=1. One break entry then follows, as in R5.
- R7: The queue holds 8 entries in arrival order. `rdValid` and the head fields show the oldest entry, `popReq` removes it, and `fillCount` gives the occupancy.
- R8: A character finished while 8 are held is dropped, the 8 stored entries are kept, and `overrun` is set. `overrun` stays set until a `cmdClrOvr` pulse.
- R9: `rxIrq` is high while `fillCount` is at least the level chosen by `cfgIrqLevel`. The codes 00, 01, 10 and 11 select 1, 3, 6 and 8 characters.
- R10: `wdogIrq` rises once the queue has been non-empty for 64 bit times with no character completed and no pop. A completed character or a pop clears it and restarts the count.
- R11: With `cfgX1`=1 the line is sampled on each rising edge of `extClk`. The first low sample is taken as the start bit, and each following edge samples one bit.
- R12: After reset the queue is empty, and `rxIrq`, `wdogIrq`, `overrun`, `breakStart` and `breakEnd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxIn | input | 1 | Serial line, high when idle |
| baudTick | input | 1 | 16X sample enable, one cycle wide |
| extClk | input | 1 | External bit-rate clock for 1X mode |
| cfgX1 | input | 1 | 1: sample on `extClk` rising edges |
| cfgDataBits | input | 2 | Data bits minus 5 |
| cfgParMode | input | 2 | Parity check mode |
| cfgForceVal | input | 1 | Expected parity bit in fixed mode |
| cfgIrqLevel | input | 2 | Fill interrupt level code |
| popReq | input | 1 | Remove head entry |
| cmdClrOvr | input | 1 | Clear the overrun flag |
| rdValid | output | 1 | Queue not empty |
| rdData | output | 8 | Head character |
| rdParErr | output | 1 | Head parity error |
| rdFrmErr | output | 1 | Head framing error |
| rdBrk | output | 1 | Head is a break entry |
| fillCount | output | 4 | Entries held |
| rxIrq | output | 1 | Fill level reached |
| wdogIrq | output | 1 | Idle watchdog expired |
| overrun | output | 1 | Sticky overrun flag |
| breakStart | output | 1 | Break begun pulse |
| breakEnd | output | 1 | Break ended pulse |

## Verification
A character is written on the clock edge of its stop-bit centre sample. The fill count, fill interrupt and head fields change one cycle after that edge. The break pulses appear one cycle after the sampling edge that decides them. The watchdog flag is due one to two cycles after the 64th bit time following the last character or pop, and a pop clears it on the next edge.

The bench changes inputs and reads outputs on falling clock edges only. It checks queue state only after a frame's whole stop bit plus one idle bit have gone by, when every update is complete. It checks the watchdog at 59.5 and 67.5 bit times, on either side of its threshold, so that tick phase does not affect the result.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_BRK
  } rxState_e;

  // strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic clrFrame;
    logic takeData;
    logic takePar;
    logic takeStop;
  } rxStrobe_t;

  // one queue entry
  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rxEntry_t;

endpackage

// File: rtl/rxw_ctrl.sv
module rxw_ctrl
  import rxw_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int WD_BITS = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxIn,
  input  logic       baudTick,
  input  logic       extClk,
  input  logic       cfgX1,
  input  logic [1:0] cfgDataBits,
  input  logic       cfgParOn,
  input  logic       frameAllZero,
  input  logic       fifoEmpty,
  input  logic       popDone,
  output rxStrobe_t  strobe,
  output logic       breakStart,
  output logic       breakEnd,
  output logic       wdogIrq
);

  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] PH_MID = PH_W'(OVS / 2 - 1);
  localparam logic [PH_W-1:0] PH_END = PH_W'(OVS - 1);
  localparam int WD_W = $clog2(WD_BITS + 1);
  localparam logic [WD_W-1:0] WD_LIMIT = WD_W'(WD_BITS);

  rxState_e        state, stateNx;
  logic [PH_W-1:0] phase;
  logic [2:0]      bitIdx;
  logic [2:0]      lastIdx;
  logic            extQ;
  logic            extRise;
  logic            smpTick;
  logic            sampleNow;
  logic            brkStartNx, brkEndNx;

  // 1X clock edge detect
  always_ff @(posedge clk) begin
    if (!rstN) extQ <= 1'b0;
    else       extQ <= extClk;
  end

  assign extRise = extClk & ~extQ;
  assign smpTick = cfgX1 ? extRise : baudTick;
  assign lastIdx = 3'd4 + {1'b0, cfgDataBits};

  always_comb begin
    if (cfgX1) sampleNow = smpTick;
    else       sampleNow = smpTick && (phase == ((state == RX_START) ? PH_MID : PH_END));
  end

  always_comb begin
    stateNx    = state;
    strobe     = '0;
    brkStartNx = 1'b0;
    brkEndNx   = 1'b0;
    case (state)
      RX_IDLE: begin
        if (smpTick && !rxIn) begin
          if (cfgX1) begin
            stateNx         = RX_DATA;
            strobe.clrFrame = 1'b1;
          end else begin
            stateNx = RX_START;
          end
        end
      end
      RX_START: begin
        if (sampleNow) begin
          if (rxIn) begin
            stateNx = RX_IDLE;
          end else begin
            stateNx         = RX_DATA;
            strobe.clrFrame = 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (sampleNow) begin
          strobe.takeData = 1'b1;
          if (bitIdx == lastIdx) stateNx = cfgParOn ? RX_PAR : RX_STOP;
        end
      end
      RX_PAR: begin
        if (sampleNow) begin
          strobe.takePar = 1'b1;
          stateNx        = RX_STOP;
        end
      end
      RX_STOP: begin
        if (sampleNow) begin
          strobe.takeStop = 1'b1;
          if (rxIn) begin
            stateNx = RX_IDLE;
          end else if (frameAllZero) begin
            stateNx    = RX_BRK;
            brkStartNx = 1'b1;
          end else begin
            stateNx         = RX_DATA;
            strobe.clrFrame = 1'b1;
          end
        end
      end
      RX_BRK: begin
        if (smpTick && rxIn) begin
          stateNx  = RX_IDLE;
          brkEndNx = 1'b1;
        end
      end
      default: stateNx = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= RX_IDLE;
      phase      <= '0;
      bitIdx     <= '0;
      breakStart <= 1'b0;
      breakEnd   <= 1'b0;
    end else begin
      state      <= stateNx;
      breakStart <= brkStartNx;
      breakEnd   <= brkEndNx;
      if (state == RX_IDLE || sampleNow || stateNx != state) phase <= '0;
      else if (smpTick)                                      phase <= phase + 1'b1;
      if (strobe.clrFrame)      bitIdx <= '0;
      else if (strobe.takeData) bitIdx <= bitIdx + 1'b1;
    end
  end

  // idle watchdog, counted in bit times
  logic [PH_W-1:0] wdPre;
  logic [WD_W-1:0] wdCnt;
  logic            wdRearm;
  logic            bitTick;

  assign wdRearm = strobe.takeStop | popDone;
  assign bitTick = cfgX1 ? extRise : (baudTick && wdPre == PH_END);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdPre   <= '0;
      wdCnt   <= '0;
      wdogIrq <= 1'b0;
    end else if (wdRearm || fifoEmpty) begin
      wdPre   <= '0;
      wdCnt   <= '0;
      wdogIrq <= 1'b0;
    end else begin
      if (baudTick)                       wdPre <= wdPre + 1'b1;
      if (bitTick && wdCnt != WD_LIMIT)   wdCnt <= wdCnt + 1'b1;
      if (wdCnt == WD_LIMIT)              wdogIrq <= 1'b1;
    end
  end

  // R4
  false_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_START && sampleNow && rxIn) |=> (state == RX_IDLE && !strobe.takeStop));

  // R10
  wdog_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdogIrq |-> !fifoEmpty);

endmodule

// File: rtl/rxw_dpath.sv
module rxw_dpath
  import rxw_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_B = 3,
  parameter int LVL_C = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rxIn,
  input  rxStrobe_t                  strobe,
  input  logic [1:0]                 cfgDataBits,
  input  logic [1:0]                 cfgParMode,
  input  logic                       cfgForceVal,
  input  logic [1:0]                 cfgIrqLevel,
  input  logic                       popReq,
  input  logic                       cmdClrOvr,
  output logic                       frameAllZero,
  output logic                       fifoEmpty,
  output logic                       popDone,
  output rxEntry_t                   head,
  output logic [$clog2(DEPTH+1)-1:0] fillCount,
  output logic                       rxIrq,
  output logic                       overrun
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // frame assembly
  logic [7:0] shiftQ;
  logic       parQ;
  logic [7:0] dataAligned;
  logic       dataOnes;
  logic       parBad;
  rxEntry_t   newEntry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      parQ   <= 1'b0;
    end else if (strobe.clrFrame) begin
      shiftQ <= '0;
      parQ   <= 1'b0;
    end else begin
      if (strobe.takeData) shiftQ <= {rxIn, shiftQ[7:1]};
      if (strobe.takePar)  parQ   <= rxIn;
    end
  end

  assign dataAligned  = shiftQ >> (2'd3 - cfgDataBits);
  assign dataOnes     = ^dataAligned;
  assign frameAllZero = (shiftQ == 8'h00) && !parQ;

  always_comb begin
    case (cfgParMode)
      2'b01:   parBad = dataOnes ^ parQ;
      2'b10:   parBad = ~(dataOnes ^ parQ);
      2'b11:   parBad = parQ ^ cfgForceVal;
      default: parBad = 1'b0;
    endcase
  end

  always_comb begin
    newEntry.frm  = ~rxIn;
    newEntry.brk  = ~rxIn & frameAllZero;
    newEntry.par  = parBad;
    newEntry.data = dataAligned;
  end

  // character queue
  rxEntry_t         mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             pushOk;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign fifoEmpty = (count == '0);
  assign popDone   = popReq && !fifoEmpty;
  assign pushOk    = strobe.takeStop && (count != FULL_CNT);

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (pushOk)  wrPtr <= nextPtr(wrPtr);
      if (popDone) rdPtr <= nextPtr(rdPtr);
      case ({pushOk, popDone})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strobe.takeStop && count == FULL_CNT) overrun <= 1'b1;
      else if (cmdClrOvr)                       overrun <= 1'b0;
    end
  end

  assign head      = mem[rdPtr];
  assign fillCount = count;

  // fill interrupt
  logic [CNT_W-1:0] irqLevel;
  always_comb begin
    case (cfgIrqLevel)
      2'b00:   irqLevel = CNT_W'(1);
      2'b01:   irqLevel = CNT_W'(LVL_B);
      2'b10:   irqLevel = CNT_W'(LVL_C);
      default: irqLevel = FULL_CNT;
    endcase
  end
  assign rxIrq = (count >= irqLevel);

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R7
  push_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeStop && count != FULL_CNT && !popDone) |=> (count == $past(count) + CNT_W'(1)));

  // R8
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeStop && count == FULL_CNT && !popReq) |=> (count == FULL_CNT && overrun));

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !cmdClrOvr) |=> overrun);

endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel
  import rxw_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int OVS     = 16,
  parameter int WD_BITS = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rxIn,
  input  logic                       baudTick,
  input  logic                       extClk,
  input  logic                       cfgX1,
  input  logic [1:0]                 cfgDataBits,
  input  logic [1:0]                 cfgParMode,
  input  logic                       cfgForceVal,
  input  logic [1:0]                 cfgIrqLevel,
  input  logic                       popReq,
  input  logic                       cmdClrOvr,
  output logic                       rdValid,
  output logic [7:0]                 rdData,
  output logic                       rdParErr,
  output logic                       rdFrmErr,
  output logic                       rdBrk,
  output logic [$clog2(DEPTH+1)-1:0] fillCount,
  output logic                       rxIrq,
  output logic                       wdogIrq,
  output logic                       overrun,
  output logic                       breakStart,
  output logic                       breakEnd
);

  rxStrobe_t strobe;
  rxEntry_t  head;
  logic      frameAllZero;
  logic      fifoEmpty;
  logic      popDone;

  rxw_ctrl #(.OVS(OVS), .WD_BITS(WD_BITS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rxIn         (rxIn),
    .baudTick     (baudTick),
    .extClk       (extClk),
    .cfgX1        (cfgX1),
    .cfgDataBits  (cfgDataBits),
    .cfgParOn     (cfgParMode != 2'b00),
    .frameAllZero (frameAllZero),
    .fifoEmpty    (fifoEmpty),
    .popDone      (popDone),
    .strobe       (strobe),
    .breakStart   (breakStart),
    .breakEnd     (breakEnd),
    .wdogIrq      (wdogIrq)
  );

  rxw_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .rxIn         (rxIn),
    .strobe       (strobe),
    .cfgDataBits  (cfgDataBits),
    .cfgParMode   (cfgParMode),
    .cfgForceVal  (cfgForceVal),
    .cfgIrqLevel  (cfgIrqLevel),
    .popReq       (popReq),
    .cmdClrOvr    (cmdClrOvr),
    .frameAllZero (frameAllZero),
    .fifoEmpty    (fifoEmpty),
    .popDone      (popDone),
    .head         (head),
    .fillCount    (fillCount),
    .rxIrq        (rxIrq),
    .overrun      (overrun)
  );

  assign rdValid  = !fifoEmpty;
  assign rdData   = head.data;
  assign rdParErr = head.par;
  assign rdFrmErr = head.frm;
  assign rdBrk    = head.brk;

endmodule

// File: tb/serial_rx_channel_bench.sv
module serial_rx_channel_bench;

  localparam int BT = 64;  // clocks per bit: a tick every 4 clocks, 16 ticks per bit

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxIn = 1'b1;
  logic       baudTick = 1'b0;
  logic       extClk = 1'b0;
  logic       cfgX1 = 1'b0;
  logic [1:0] cfgDataBits = 2'd3;
  logic [1:0] cfgParMode = 2'd0;
  logic       cfgForceVal = 1'b0;
  logic [1:0] cfgIrqLevel = 2'd0;
  logic       popReq = 1'b0;
  logic       cmdClrOvr = 1'b0;
  logic       rdValid, rdParErr, rdFrmErr, rdBrk, rxIrq, wdogIrq, overrun, breakStart, breakEnd;
  logic [7:0] rdData;
  logic [3:0] fillCount;

  serial_rx_channel u_serial_rx_channel (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .baudTick(baudTick), .extClk(extClk),
    .cfgX1(cfgX1), .cfgDataBits(cfgDataBits), .cfgParMode(cfgParMode),
    .cfgForceVal(cfgForceVal), .cfgIrqLevel(cfgIrqLevel), .popReq(popReq),
    .cmdClrOvr(cmdClrOvr), .rdValid(rdValid), .rdData(rdData), .rdParErr(rdParErr),
    .rdFrmErr(rdFrmErr), .rdBrk(rdBrk), .fillCount(fillCount), .rxIrq(rxIrq),
    .wdogIrq(wdogIrq), .overrun(overrun), .breakStart(breakStart), .breakEnd(breakEnd)
  );

  always #5 clk = ~clk;

  logic [1:0] tickDiv = 2'd0;
  always @(negedge clk) begin
    tickDiv  <= tickDiv + 2'd1;
    baudTick <= (tickDiv == 2'd3);
  end

  int brkStartCnt = 0;
  int brkEndCnt = 0;
  always @(negedge clk) begin
    if (breakStart) brkStartCnt++;
    if (breakEnd)   brkEndCnt++;
  end

  int checks = 0;
  int fails = 0;
  logic [10:0] modelQ[$];
  bit ovrExp = 1'b0;

  task automatic checkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit parBit(logic [7:0] d, logic [1:0] mode, bit fv);
    case (mode)
      2'd1:    return ^d;
      2'd2:    return ~^d;
      2'd3:    return fv;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int lvlOf(logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 3;
      2'd2:    return 6;
      default: return 8;
    endcase
  endfunction

  task automatic modelPush(logic [10:0] e);
    if (modelQ.size() < 8) modelQ.push_back(e);
    else ovrExp = 1'b1;
  endtask

  task automatic sendLevel(bit v, int bits);
    rxIn = v;
    repeat (bits * BT) @(negedge clk);
  endtask

  // 16X frame using the current configuration; badPar flips the parity bit
  task automatic sendFrame(logic [7:0] d, bit badPar);
    int nb;
    logic [7:0] dm;
    nb = 5 + int'(cfgDataBits);
    dm = d & ((8'd1 << nb) - 8'd1);
    sendLevel(1'b0, 1);
    for (int i = 0; i < nb; i++) sendLevel(dm[i], 1);
    if (cfgParMode != 2'd0) sendLevel(parBit(dm, cfgParMode, cfgForceVal) ^ badPar, 1);
    sendLevel(1'b1, 2);
    modelPush({1'b0, 1'b0, badPar && (cfgParMode != 2'd0), dm});
  endtask

  task automatic bit1x(bit v);
    rxIn = v;
    repeat (8) @(negedge clk);
    extClk = 1'b1;
    repeat (8) @(negedge clk);
    extClk = 1'b0;
  endtask

  task automatic sendFrame1x(logic [7:0] d);
    int nb;
    logic [7:0] dm;
    nb = 5 + int'(cfgDataBits);
    dm = d & ((8'd1 << nb) - 8'd1);
    bit1x(1'b0);
    for (int i = 0; i < nb; i++) bit1x(dm[i]);
    if (cfgParMode != 2'd0) bit1x(parBit(dm, cfgParMode, cfgForceVal));
    bit1x(1'b1);
    bit1x(1'b1);
    modelPush({3'b000, dm});
  endtask

  task automatic checkLevels(string req);
    checkEq(req, "fillCount", int'(fillCount), modelQ.size());
    checkEq(req, "rdValid", int'(rdValid), int'(modelQ.size() != 0));
    checkEq("R9", "rxIrq", int'(rxIrq), int'(modelQ.size() >= lvlOf(cfgIrqLevel)));
    checkEq("R8", "overrun", int'(overrun), int'(ovrExp));
  endtask

  task automatic popCheck(string req);
    logic [10:0] exp;
    checkEq(req, "rdValid before pop", int'(rdValid), 1);
    if (modelQ.size() != 0) begin
      exp = modelQ.pop_front();
      checkEq(req, "head {brk,frm,par,data}", int'({rdBrk, rdFrmErr, rdParErr, rdData}), int'(exp));
    end
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
  endtask

  task automatic drainAll(string req);
    while (modelQ.size() != 0) popCheck(req);
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int b0, e0;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R12 reset state
    checkEq("R12", "fillCount", int'(fillCount), 0);
    checkEq("R12", "rdValid", int'(rdValid), 0);
    checkEq("R12", "rxIrq", int'(rxIrq), 0);
    checkEq("R12", "wdogIrq", int'(wdogIrq), 0);
    checkEq("R12", "overrun", int'(overrun), 0);
    checkEq("R12", "break pulses", brkStartCnt + brkEndCnt, 0);

    // R1 lengths, LSB first
    sendLevel(1'b1, 2);
    for (int n = 0; n < 4; n++) begin
      cfgDataBits = 2'(n);
      sendFrame(8'hA6 + 8'(n * 17), 1'b0);
      checkLevels("R1");
      popCheck("R1");
    end

    // R2 parity modes, good and bad
    for (int m = 1; m < 4; m++) begin
      cfgParMode = 2'(m);
      cfgDataBits = 2'd2;
      cfgForceVal = (m == 3);
      sendFrame(8'h35, 1'b0);
      sendFrame(8'h4B, 1'b1);
      checkLevels("R2");
      popCheck("R2");
      popCheck("R2");
    end
    cfgParMode = 2'd0;
    cfgDataBits = 2'd3;

    // R4 false start
    rxIn = 1'b0;
    repeat (12) @(negedge clk);
    sendLevel(1'b1, 3);
    checkEq("R4", "fillCount after glitch", int'(fillCount), 0);
    sendFrame(8'hC3, 1'b0);
    checkLevels("R4");
    popCheck("R4");

    // R3 framing error then resync
    sendLevel(1'b0, 1);
    for (int i = 0; i < 8; i++) sendLevel(1'(8'h55 >> i), 1);
    sendLevel(1'b0, 1);
    sendLevel(1'b1, 12);
    modelPush({3'b010, 8'h55});
    modelPush({3'b000, 8'hFF});
    checkLevels("R3");
    drainAll("R3");

    // R6 break starting inside a character
    b0 = brkStartCnt;
    e0 = brkEndCnt;
    sendLevel(1'b0, 1);
    for (int i = 0; i < 8; i++) sendLevel(1'(8'h2C >> i), 1);
    sendLevel(1'b0, 22);
    modelPush({3'b010, 8'h2C});
    modelPush({3'b110, 8'h00});
    checkEq("R6", "breakStart pulses", brkStartCnt - b0, 1);
    checkEq("R6", "breakEnd before line high", brkEndCnt - e0, 0);
    sendLevel(1'b1, 3);
    checkEq("R6", "breakEnd pulses", brkEndCnt - e0, 1);
    checkLevels("R6");
    drainAll("R6");

    // R5 break from idle
    b0 = brkStartCnt;
    e0 = brkEndCnt;
    sendLevel(1'b0, 20);
    checkEq("R5", "fillCount during break", int'(fillCount), 1);
    checkEq("R5", "breakStart pulses", brkStartCnt - b0, 1);
    sendLevel(1'b1, 3);
    checkEq("R5", "breakEnd pulses", brkEndCnt - e0, 1);
    modelPush({3'b110, 8'h00});
    checkLevels("R5");
    drainAll("R5");

    // R8 / R9 fill to overflow at level 8
    cfgIrqLevel = 2'd3;
    for (int i = 0; i < 9; i++) begin
      sendFrame(8'(32'h10 + i * 7), 1'b0);
      checkLevels("R8");
    end
    popCheck("R8");
    popCheck("R8");
    checkEq("R8", "overrun held across pops", int'(overrun), 1);
    cmdClrOvr = 1'b1;
    @(negedge clk);
    cmdClrOvr = 1'b0;
    ovrExp = 1'b0;
    checkEq("R8", "overrun after clear", int'(overrun), 0);
    drainAll("R8");

    // R10 watchdog
    cfgIrqLevel = 2'd0;
    sendFrame(8'h77, 1'b0);
    repeat (58 * BT) @(negedge clk);
    checkEq("R10", "wdogIrq before 64 bits", int'(wdogIrq), 0);
    repeat (8 * BT) @(negedge clk);
    checkEq("R10", "wdogIrq after 64 bits", int'(wdogIrq), 1);
    popCheck("R10");
    checkEq("R10", "wdogIrq after pop", int'(wdogIrq), 0);
    repeat (70 * BT) @(negedge clk);
    checkEq("R10", "wdogIrq while empty", int'(wdogIrq), 0);

    // R11 external 1X clock
    cfgX1 = 1'b1;
    cfgDataBits = 2'd2;
    cfgParMode = 2'd2;
    sendFrame1x(8'h5A);
    cfgDataBits = 2'd0;
    cfgParMode = 2'd0;
    sendFrame1x(8'h13);
    checkLevels("R11");
    drainAll("R11");
    cfgX1 = 1'b0;
    sendLevel(1'b1, 2);

    // random frames with random pops
    for (int k = 0; k < 40; k++) begin
      cfgDataBits = 2'($urandom % 4);
      cfgParMode  = 2'($urandom % 4);
      cfgForceVal = 1'($urandom % 2);
      cfgIrqLevel = 2'($urandom % 4);
      sendFrame(8'($urandom), ($urandom % 4) == 0);
      checkLevels("R7");
      for (int p = 0; p < int'($urandom % 3); p++)
        if (modelQ.size() != 0) popCheck("R7");
      if (ovrExp && ($urandom % 2) == 0) begin
        cmdClrOvr = 1'b1;
        @(negedge clk);
        cmdClrOvr = 1'b0;
        ovrExp = 1'b0;
      end
    end
    checkLevels("R7");
    drainAll("R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule